// File: doc/BRIEF.md
# Processor Bus Master Transaction Engine

This block is the master side of a processor bus, for a local requester that issues one transaction at a time. A one-cycle start pulse, given while the engine is idle, captures a request. The request carries a command code, an address, write data, the read data expected back and an expected fault value. The engine then runs a fixed four-phase sequence on a multiplexed address/data bus. The address goes out first. Write data goes out next for the store-type commands. The last phase samples the slave's reject, fault and read-data lines.

A slave that raises reject in the last phase makes the engine re-issue the whole transaction from phase 0. When a final phase is not rejected, the engine ends the transaction. It gives a one-cycle done pulse and three error flags: read data that differs from the expected value, a fault code that differs from the expected one, and an expected fault that never arrived. Two static outputs also go out on the bus: the privilege mode (kernel or user) and a byte-select mask. A separate configuration strobe loads both.

Top module: `pbus_master_engine`

## Requirements
- R1: After reset the engine is idle, with `busy`=0, `done`=0, `bus_cmd`=0, `bus_dout`=0, all error flags 0, `bus_mode`=0 (kernel) and `bus_bytesel`=4'hF (full word).
- R2: A `start` seen while idle captures the request. During each of the four phases that follow, `bus_cmd` carries the captured code: 8 read, 9 write, 10 conditional-write-single, 11 demap, 12 I/O read, 13 I/O write, 14 clear-virtual-page, 15 broadcast I/O write. A `start` seen while busy changes neither the command nor the address on the bus. While idle, `bus_cmd` is 0.
- R3: In phases 0 and 1, `bus_dout` carries the captured address. The exception is command 14, which drives 0.
- R4: For commands 9, 13 and 15, `bus_dout` carries the write data in phases 2 and 3. Every other command keeps the address on `bus_dout` in phase 2 and, except as follows, in phase 3. Command 11 drives 0 in phase 3. Command 14 drives 0 in both phases.
- R5: If `bus_reject` is 1 in phase 3, the next cycle is phase 0 of the same transaction, with the address driven again and no `done`. `bus_reject` has no effect in phases 0 to 2.
- R6: If `bus_reject` is 0 in phase 3, `done` is 1 for exactly the next cycle and `busy` is 0 in that cycle. An unrejected attempt therefore takes exactly four busy cycles.
- R7: For commands 8, 12 and 10, `bus_din` is sampled in the unrejected phase 3. If it differs from the expected data, `err_data` is set. No other command ever sets `err_data`.
- R8: Whenever `bus_fault` is 1 in phase 3 of any attempt, the observed fault value is 16 plus `bus_fault_code`. If that value differs from `req_fault_exp`, `err_fault` is set. `bus_fault` in phases 0 to 2 is ignored.
- R9: For commands 8 and 10 only, if `req_fault_exp` is nonzero and `bus_fault` was 0 in phase 3 of every attempt, `err_nofault` is set at completion.
- R10: `cfg_we` loads `bus_mode` from `cfg_user` (0 kernel, 1 user) and loads `bus_bytesel` from `cfg_bytesel`. Without `cfg_we` both outputs hold, whatever the transaction activity.
- R11: The error flags are cleared when a start is accepted. They hold their values from `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, taken only while idle |
| req_cmd | input | 4 | Command code |
| req_addr | input | DW | Transaction address |
| req_wdata | input | DW | Write data |
| req_expect | input | DW | Expected read data |
| req_fault_exp | input | FXW | Expected fault value (0 = none) |
| cfg_we | input | 1 | Load mode and byte select |
| cfg_user | input | 1 | Mode to load, 1 = user |
| cfg_bytesel | input | BSW | Byte-select mask to load |
| bus_reject | input | 1 | Slave reject, sampled in phase 3 |
| bus_fault | input | 1 | Slave fault flag, sampled in phase 3 |
| bus_fault_code | input | FCW | Slave fault code |
| bus_din | input | DW | Read data from slave |
| bus_cmd | output | 4 | Command on bus, 0 while idle |
| bus_dout | output | DW | Multiplexed address/data |
| bus_mode | output | 1 | 0 kernel, 1 user |
| bus_bytesel | output | BSW | Byte-select mask |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err_data | output | 1 | Read data mismatch |
| err_fault | output | 1 | Fault code mismatch |
| err_nofault | output | 1 | Expected fault absent |

## Verification
The hardest state to reach is a transaction with a mixed history, where some rejected attempts carried faults and others did not. The verdict then depends on faults that arrived before the final attempt. `err_nofault` must also stay clear when the only fault came on a rejected attempt. The bench drives this with a per-attempt fault mask on multi-reject transactions. During phases 0 to 2 it holds reject and fault high, with wrong codes and wrong data, to show those phases ignore them. It also pulses `start` in the middle of a transaction to show that a busy engine keeps its request.

// File: rtl/pbm_pkg.sv
// Package: command codes, phase type and command-class helpers shared by
// the processor bus master engine. Assumes a 4-bit command bus.
package pbm_pkg;

    localparam logic [3:0] CMD_IDLE   = 4'd0;
    localparam logic [3:0] CMD_READ   = 4'd8;
    localparam logic [3:0] CMD_WRITE  = 4'd9;
    localparam logic [3:0] CMD_CWS    = 4'd10;
    localparam logic [3:0] CMD_DEMAP  = 4'd11;
    localparam logic [3:0] CMD_IORD   = 4'd12;
    localparam logic [3:0] CMD_IOWR   = 4'd13;
    localparam logic [3:0] CMD_CLRVP  = 4'd14;
    localparam logic [3:0] CMD_BIOWR  = 4'd15;

    localparam int FAULT_BASE = 16;

    typedef enum logic [1:0] {
        PH_ADDR0   = 2'd0,
        PH_ADDR1   = 2'd1,
        PH_DATA    = 2'd2,
        PH_RESOLVE = 2'd3
    } phase_t;

    // Commands that put write data on the bus in phases 2 and 3.
    function automatic logic cmd_stores(input logic [3:0] c);
        return (c == CMD_WRITE) || (c == CMD_IOWR) || (c == CMD_BIOWR);
    endfunction

    // Commands whose returned data is compared with the expected value.
    function automatic logic cmd_returns(input logic [3:0] c);
        return (c == CMD_READ) || (c == CMD_IORD) || (c == CMD_CWS);
    endfunction

    // Commands for which an expected fault must actually occur.
    function automatic logic cmd_demands_fault(input logic [3:0] c);
        return (c == CMD_READ) || (c == CMD_CWS);
    endfunction

endpackage

// File: rtl/pbm_sequencer.sv
// Phase sequencer: accepts a start while idle, steps phases 0..3 and
// either restarts at phase 0 on reject or ends with a one-cycle done.
// Assumes reject is only meaningful in phase 3.
module pbm_sequencer
    import pbm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   bus_reject,
    output logic   active,
    output phase_t phase,
    output logic   launch,
    output logic   resolve,
    output logic   done
);
    logic finish;

    // Decode accept, resolve-phase and completion conditions.
    always_comb begin
        launch  = start && !active;
        resolve = active && (phase == PH_RESOLVE);
        finish  = resolve && !bus_reject;
    end

    // Advance the phase counter and track the busy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            phase  <= PH_ADDR0;
            done   <= 1'b0;
        end else begin
            done <= finish;
            if (launch) begin
                active <= 1'b1;
                phase  <= PH_ADDR0;
            end else if (resolve) begin
                phase <= PH_ADDR0;
                if (!bus_reject) active <= 1'b0;
            end else if (active) begin
                phase <= phase_t'(phase + 2'd1);
            end
        end
    end
endmodule

// File: rtl/pbm_drive.sv
// Bus driver: selects the command and multiplexed address/data value for
// the current phase. Purely combinational; assumes registered inputs.
module pbm_drive
    import pbm_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          active,
    input  phase_t        phase,
    input  logic [3:0]    cmd,
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [3:0]    bus_cmd,
    output logic [DW-1:0] bus_dout
);
    logic          zero_addr;
    logic          zero_tail;
    logic [DW-1:0] addr_eff;

    // Choose the per-phase value for the data-out bus.
    always_comb begin
        zero_addr = (cmd == CMD_CLRVP);
        zero_tail = (cmd == CMD_CLRVP) || (cmd == CMD_DEMAP);
        addr_eff  = zero_addr ? '0 : addr;
        bus_cmd   = active ? cmd : CMD_IDLE;
        bus_dout  = '0;
        if (active) begin
            unique case (phase)
                PH_ADDR0, PH_ADDR1: bus_dout = addr_eff;
                PH_DATA:            bus_dout = cmd_stores(cmd) ? wdata : addr_eff;
                PH_RESOLVE:         bus_dout = cmd_stores(cmd) ? wdata
                                             : (zero_tail ? '0 : addr);
                default:            bus_dout = '0;
            endcase
        end
    end
endmodule

// File: rtl/pbm_verdict.sv
// Verdict logic: checks fault codes in every phase 3, compares returned
// data and flags a missing expected fault at completion. Flags clear on
// launch and are sticky within one transaction.
module pbm_verdict
    import pbm_pkg::*;
#(
    parameter int DW  = 32,
    parameter int FCW = 4,
    parameter int FXW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           launch,
    input  logic           resolve,
    input  logic           bus_reject,
    input  logic [3:0]     cmd,
    input  logic [DW-1:0]  expect_data,
    input  logic [FXW-1:0] expect_fault,
    input  logic [DW-1:0]  bus_din,
    input  logic           bus_fault,
    input  logic [FCW-1:0] bus_fault_code,
    output logic           err_data,
    output logic           err_fault,
    output logic           err_nofault
);
    localparam logic [FXW-1:0] BASE = FXW'(FAULT_BASE);

    logic [FXW-1:0] observed;
    logic           fault_seen;

    // Form the observed fault value from the slave's code.
    always_comb observed = BASE + FXW'(bus_fault_code);

    // Update fault history and error flags on resolve phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_seen  <= 1'b0;
            err_data    <= 1'b0;
            err_fault   <= 1'b0;
            err_nofault <= 1'b0;
        end else if (launch) begin
            fault_seen  <= 1'b0;
            err_data    <= 1'b0;
            err_fault   <= 1'b0;
            err_nofault <= 1'b0;
        end else if (resolve) begin
            if (bus_fault) begin
                fault_seen <= 1'b1;
                if (observed != expect_fault) err_fault <= 1'b1;
            end
            if (!bus_reject) begin
                err_data    <= cmd_returns(cmd) && (bus_din != expect_data);
                err_nofault <= cmd_demands_fault(cmd) && (expect_fault != '0)
                               && !(fault_seen || bus_fault);
            end
        end
    end
endmodule

// File: rtl/pbus_master_engine.sv
// Top: processor bus master transaction engine. Captures one request on
// start, runs the four-phase bus sequence through the sequencer, driver
// and verdict units, and holds the static mode and byte-select outputs.
// Assumes the requester waits for done before the next start.
module pbus_master_engine
    import pbm_pkg::*;
#(
    parameter int DW  = 32,
    parameter int BSW = 4,
    parameter int FCW = 4,
    parameter int FXW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [3:0]     req_cmd,
    input  logic [DW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    input  logic [DW-1:0]  req_expect,
    input  logic [FXW-1:0] req_fault_exp,
    input  logic           cfg_we,
    input  logic           cfg_user,
    input  logic [BSW-1:0] cfg_bytesel,
    input  logic           bus_reject,
    input  logic           bus_fault,
    input  logic [FCW-1:0] bus_fault_code,
    input  logic [DW-1:0]  bus_din,
    output logic [3:0]     bus_cmd,
    output logic [DW-1:0]  bus_dout,
    output logic           bus_mode,
    output logic [BSW-1:0] bus_bytesel,
    output logic           busy,
    output logic           done,
    output logic           err_data,
    output logic           err_fault,
    output logic           err_nofault
);
    localparam logic [BSW-1:0] FULL_WORD = '1;

    logic           active;
    phase_t         phase;
    logic           launch;
    logic           resolve;
    logic [3:0]     cmd_q;
    logic [DW-1:0]  addr_q;
    logic [DW-1:0]  wdata_q;
    logic [DW-1:0]  expect_q;
    logic [FXW-1:0] fexp_q;

    // Capture the request fields when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= CMD_IDLE;
            addr_q   <= '0;
            wdata_q  <= '0;
            expect_q <= '0;
            fexp_q   <= '0;
        end else if (launch) begin
            cmd_q    <= req_cmd;
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            expect_q <= req_expect;
            fexp_q   <= req_fault_exp;
        end
    end

    // Hold the static mode and byte-select outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_mode    <= 1'b0;
            bus_bytesel <= FULL_WORD;
        end else if (cfg_we) begin
            bus_mode    <= cfg_user;
            bus_bytesel <= cfg_bytesel;
        end
    end

    pbm_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .bus_reject (bus_reject),
        .active     (active),
        .phase      (phase),
        .launch     (launch),
        .resolve    (resolve),
        .done       (done)
    );

    pbm_drive #(.DW(DW)) u_drive (
        .active   (active),
        .phase    (phase),
        .cmd      (cmd_q),
        .addr     (addr_q),
        .wdata    (wdata_q),
        .bus_cmd  (bus_cmd),
        .bus_dout (bus_dout)
    );

    pbm_verdict #(.DW(DW), .FCW(FCW), .FXW(FXW)) u_verdict (
        .clk            (clk),
        .rst_n          (rst_n),
        .launch         (launch),
        .resolve        (resolve),
        .bus_reject     (bus_reject),
        .cmd            (cmd_q),
        .expect_data    (expect_q),
        .expect_fault   (fexp_q),
        .bus_din        (bus_din),
        .bus_fault      (bus_fault),
        .bus_fault_code (bus_fault_code),
        .err_data       (err_data),
        .err_fault      (err_fault),
        .err_nofault    (err_nofault)
    );

    // Report busy from the sequencer state.
    always_comb busy = active;
endmodule

// File: rtl/pbm_sva.sv
// Checker for the bus master engine: temporal properties over its ports
// and phase state. Attached to every instance by the bind below.
module pbm_sva
    import pbm_pkg::*;
#(
    parameter int BSW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           bus_reject,
    input logic [3:0]     bus_cmd,
    input logic           busy,
    input logic           done,
    input logic           err_data,
    input logic           err_nofault,
    input logic           cfg_we,
    input logic           bus_mode,
    input logic [BSW-1:0] bus_bytesel,
    input phase_t         phase
);
    assert_cmd_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(bus_cmd));

    assert_start_no_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && phase != PH_RESOLVE) |=> busy);

    assert_reject_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase == PH_RESOLVE && bus_reject) |=> (busy && phase == PH_ADDR0 && !done));

    assert_done_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy && phase == PH_RESOLVE && !bus_reject) && !busy));

    assert_data_err_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_data) |-> done);

    assert_nofault_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_nofault) |-> done);

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_we) |-> ($stable(bus_mode) && $stable(bus_bytesel)));
endmodule

bind pbus_master_engine pbm_sva #(.BSW(BSW)) u_pbm_sva (.*);

// File: tb/pbus_master_engine_test.sv
// Bench: sweeps every command over reject counts and data match/mismatch,
// then fault histories, with expected values computed from the rules.
module pbus_master_engine_test;
    localparam int DW  = 32;
    localparam int BSW = 4;
    localparam int FCW = 4;
    localparam int FXW = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [3:0]     req_cmd = '0;
    logic [DW-1:0]  req_addr = '0, req_wdata = '0, req_expect = '0;
    logic [FXW-1:0] req_fault_exp = '0;
    logic           cfg_we = 1'b0, cfg_user = 1'b0;
    logic [BSW-1:0] cfg_bytesel = '0;
    logic           bus_reject = 1'b0, bus_fault = 1'b0;
    logic [FCW-1:0] bus_fault_code = '0;
    logic [DW-1:0]  bus_din = '0;
    logic [3:0]     bus_cmd;
    logic [DW-1:0]  bus_dout;
    logic           bus_mode;
    logic [BSW-1:0] bus_bytesel;
    logic           busy, done, err_data, err_fault, err_nofault;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pbus_master_engine #(.DW(DW), .BSW(BSW), .FCW(FCW), .FXW(FXW)) uut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_dout(input logic [3:0] c, input int p,
                                               input logic [DW-1:0] a, wd);
        bit st = (c == 4'd9) || (c == 4'd13) || (c == 4'd15);
        if (p < 2)  return (c == 4'd14) ? '0 : a;
        if (p == 2) return st ? wd : ((c == 4'd14) ? '0 : a);
        return st ? wd : ((c == 4'd11 || c == 4'd14) ? '0 : a);
    endfunction

    // One transaction: rej rejected attempts, fmask bit per attempt for fault.
    task automatic txn(input logic [3:0] c, input logic [DW-1:0] a, wd, ex, din,
                       input logic [FXW-1:0] fx, input int rej, input logic [3:0] fmask,
                       input logic [FCW-1:0] fcode, input bit noise, input bit poke);
        bit e_data, e_fault, e_nof, any_fault;
        e_fault = 0; any_fault = 0;
        req_cmd = c; req_addr = a; req_wdata = wd; req_expect = ex; req_fault_exp = fx;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        for (int at = 0; at <= rej; at++) begin
            for (int p = 0; p < 4; p++) begin
                if (p == 3) begin
                    bus_reject = (at < rej); bus_fault = fmask[at];
                    bus_fault_code = fcode; bus_din = din;
                    if (fmask[at]) begin
                        any_fault = 1;
                        if (FXW'(16 + int'(fcode)) != fx) e_fault = 1;
                    end
                end else if (noise) begin
                    bus_reject = 1'b1; bus_fault = 1'b1;
                    bus_fault_code = ~fcode; bus_din = ~din;
                end else begin
                    bus_reject = 1'b0; bus_fault = 1'b0;
                end
                if (poke && p == 1) begin
                    start = 1'b1; req_cmd = c ^ 4'h1; req_addr = ~a;
                end
                chk(busy == 1'b1 && done == 1'b0, "R5 busy, no done mid-transaction",
                    {busy, done}, 2'b10);
                chk(bus_cmd == c, "R2 command on bus", bus_cmd, c);
                chk(bus_dout == exp_dout(c, p, a, wd), (p < 2) ? "R3 address phase" : "R4 data phase",
                    bus_dout, exp_dout(c, p, a, wd));
                @(posedge clk); #1;
                start = 1'b0;
            end
        end
        bus_reject = 0; bus_fault = 0; bus_fault_code = 0; bus_din = 0;
        e_data = ((c == 4'd8) || (c == 4'd12) || (c == 4'd10)) && (din != ex);
        e_nof  = ((c == 4'd8) || (c == 4'd10)) && (fx != 0) && !any_fault;
        chk(done == 1'b1 && busy == 1'b0, "R6 done pulse after accepted phase 3",
            {done, busy}, 2'b10);
        chk(err_data == e_data, "R7 data compare", err_data, e_data);
        chk(err_fault == e_fault, "R8 fault code check", err_fault, e_fault);
        chk(err_nofault == e_nof, "R9 missing fault", err_nofault, e_nof);
        @(posedge clk); #1;
        chk(done == 1'b0 && bus_cmd == 4'd0, "R6 done lasts one cycle, idle cmd",
            {done, bus_cmd}, 5'd0);
        chk({err_data, err_fault, err_nofault} == {e_data, e_fault, e_nof},
            "R11 flags held after done", {err_data, err_fault, err_nofault},
            {e_data, e_fault, e_nof});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk(busy == 0 && done == 0 && bus_cmd == 0 && bus_dout == 0, "R1 idle after reset",
            {busy, done, bus_cmd, bus_dout}, 0);
        chk({err_data, err_fault, err_nofault} == 3'b000, "R1 flags clear",
            {err_data, err_fault, err_nofault}, 0);
        chk(bus_mode == 1'b0 && bus_bytesel == 4'hF, "R1 kernel mode, full word",
            {bus_mode, bus_bytesel}, 5'h0F);

        cfg_we = 1; cfg_user = 1; cfg_bytesel = 4'h3;
        @(posedge clk); #1;
        cfg_we = 0; cfg_user = 0; cfg_bytesel = 4'hC;
        chk(bus_mode == 1'b1 && bus_bytesel == 4'h3, "R10 config load",
            {bus_mode, bus_bytesel}, 5'h13);

        // Sweep: every command, 0..2 rejects, matching and mismatching data.
        for (int ci = 8; ci < 16; ci++)
            for (int r = 0; r < 3; r++)
                for (int m = 0; m < 2; m++) begin
                    logic [DW-1:0] a, ex;
                    a  = 32'h1000_0000 * ci + 32'h0101 * r + 32'h10 * m + 32'h0000_0abc;
                    ex = a ^ 32'h5a5a_0000;
                    txn(4'(ci), a, ~a, ex, m ? (ex ^ (32'h1 << (ci + r))) : ex,
                        6'd0, r, 4'b0000, 4'd0, (r == 1), 1'b0);
                end

        chk(bus_mode == 1'b1 && bus_bytesel == 4'h3, "R10 config held across traffic",
            {bus_mode, bus_bytesel}, 5'h13);

        // Fault histories: read, cws, I/O read, write.
        for (int k = 0; k < 4; k++)
            for (int fe = 0; fe < 3; fe++)
                for (int fm = 0; fm < 4; fm++) begin
                    logic [3:0] c, mask;
                    logic [5:0] fx;
                    c    = (k == 0) ? 4'd8 : (k == 1) ? 4'd10 : (k == 2) ? 4'd12 : 4'd9;
                    fx   = (fe == 0) ? 6'd0 : (fe == 1) ? 6'd21 : 6'd30;
                    mask = (fm == 0) ? 4'b0000 : (fm == 1) ? 4'b0100
                         : (fm == 2) ? 4'b0001 : 4'b0011;
                    txn(c, 32'hC000_0040 + k, 32'h1234_0000 + fe, 32'hABCD_0000 + fm,
                        32'hABCD_0000 + fm, fx, 2, mask, 4'd5, 1'b1, 1'b0);
                end

        // Start pulses while busy must not disturb the transaction.
        txn(4'd13, 32'h0000_7770, 32'hFEED_BEEF, 32'd0, 32'd0, 6'd0, 1, 4'b0, 4'd0, 1'b0, 1'b1);
        txn(4'd8, 32'h0000_8880, 32'd0, 32'h600D_600D, 32'h600D_600D, 6'd0, 0, 4'b0, 4'd0, 1'b0, 1'b1);

        cfg_we = 1; cfg_user = 0; cfg_bytesel = 4'hF;
        @(posedge clk); #1;
        cfg_we = 0;
        chk(bus_mode == 1'b0 && bus_bytesel == 4'hF, "R10 config back to kernel, full word",
            {bus_mode, bus_bytesel}, 5'h0F);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule